// File: doc/BRIEF.md
# Two-Way Set-Associative Write-Back Cache

This block sits between a processor and a slow main memory. The processor issues byte reads and byte writes on a 24-bit byte address. The cache serves them from a two-way set-associative array of 4-byte lines. The low two address bits select a byte inside a line. The next `SET_BITS` bits select the set, which is the block number modulo the number of sets. The remaining upper bits form the tag. With `SET_BITS = 13` this gives a 9-bit tag, a 13-bit set index and a 2-bit byte offset. The default is a smaller array, to keep elaboration light.

A request is accepted when `req_ready` is high. The answer arrives as a one-cycle `resp_valid` pulse. A miss talks to main memory through a request port that moves whole 4-byte blocks. Each transfer completes when memory pulses `mem_resp_valid`. Writes stay in the cache and mark the line dirty. A modified line goes back to memory only when it is chosen for replacement.

Top module: `cache2w`

## Requirements
- R1: The byte offset is `addr[1:0]`, the set is `addr[SET_BITS+1:2]` and the tag is the bits above. A block read from memory is requested at block address `addr[23:2]`. Byte k of a line occupies bits `[8k+7:8k]` of the 32-bit block.
- R2: After reset, every line is invalid, `req_ready` is 1, and `resp_valid` and `mem_req_valid` are 0.
- R3: A read whose tag matches a valid line in either way of its set returns that byte with no memory transfer.
- R4: On a read miss, the whole block is fetched first. The requested byte of the fetched block is then returned.
- R5: A write hit updates only the cached byte and marks the line dirty, with no memory transfer. The response data of a write is 0.
- R6: A write miss allocates. It fetches the block, merges the written byte into it, and leaves the line dirty. The other three bytes keep their memory values.
- R7: A refill uses an invalid way of the set before it evicts any valid way.
- R8: When both ways are valid, the victim is the way of the set that was referenced less recently. Every hit and every refill counts as a reference.
- R9: A dirty victim is written to memory, as one block write at its own block address carrying the whole line, before the refill read is issued.
- R10: A clean victim is overwritten without any memory write.
- R11: While `mem_req_valid` is high and no `mem_resp_valid` has arrived, the memory request and its address, direction and data stay unchanged.
- R12: Each accepted request produces exactly one single-cycle `resp_valid` pulse. `req_ready` is low while a memory transfer is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Processor request present |
| req_write | input | 1 | 1 = byte write, 0 = byte read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 8 | Write byte |
| req_ready | output | 1 | Cache idle, request accepted this cycle |
| resp_valid | output | 1 | One-cycle completion pulse |
| resp_rdata | output | 8 | Read byte (0 for writes) |
| mem_req_valid | output | 1 | Memory transfer requested |
| mem_req_write | output | 1 | 1 = block write-back, 0 = block fetch |
| mem_req_addr | output | ADDR_W-2 | Block address |
| mem_req_wdata | output | 32 | Block written back |
| mem_resp_valid | input | 1 | Memory completes the transfer |
| mem_resp_rdata | input | 32 | Fetched block |

## Verification
The hardest case to reach is an eviction of a dirty line whose LRU state was set by a particular mix of hits, fills and writes. That case is the only place where a write-back, the victim choice and the merged data all show together at the memory port. The bench builds it with a small configuration of four sets and short, hand-planned sequences that pile several tags into one set. It counts every memory read and write and captures the block written back. A long sweep then writes and reads back a whole 1 KiB window many times over, so that evictions of mixed clean and dirty lines happen constantly against an arithmetic golden image.

// File: rtl/cache2w.sv
module cache2w #(
  parameter int ADDR_W   = 24,
  parameter int SET_BITS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [7:0]        req_wdata,
  output logic              req_ready,
  output logic              resp_valid,
  output logic [7:0]        resp_rdata,
  output logic              mem_req_valid,
  output logic              mem_req_write,
  output logic [ADDR_W-3:0] mem_req_addr,
  output logic [31:0]       mem_req_wdata,
  input  logic              mem_resp_valid,
  input  logic [31:0]       mem_resp_rdata
);
  localparam int TAG_W = ADDR_W - SET_BITS - 2;
  localparam int SETS  = 1 << SET_BITS;

  typedef enum logic [1:0] {S_IDLE, S_CMP, S_WB, S_FILL} st_t;

  st_t               state;
  logic              q_write;
  logic [ADDR_W-1:0] q_addr;
  logic [7:0]        q_wdata;
  logic              q_way;

  logic [TAG_W-1:0]  tags  [2][SETS];
  logic [31:0]       lines [2][SETS];
  logic [SETS-1:0]   vld   [2];
  logic [SETS-1:0]   dirty [2];
  logic [SETS-1:0]   lru;

  logic [SET_BITS-1:0] set_i;
  logic [TAG_W-1:0]    tag_i;
  logic [1:0]          off_i;
  logic                hit0, hit1, hit, hway, vway;

  assign set_i = q_addr[SET_BITS+1:2];
  assign tag_i = q_addr[ADDR_W-1:SET_BITS+2];
  assign off_i = q_addr[1:0];

  assign hit0 = vld[0][set_i] && (tags[0][set_i] == tag_i);
  assign hit1 = vld[1][set_i] && (tags[1][set_i] == tag_i);
  assign hit  = hit0 | hit1;
  assign hway = hit1;
  assign vway = !vld[0][set_i] ? 1'b0 : (!vld[1][set_i] ? 1'b1 : lru[set_i]);

  function automatic logic [31:0] put_byte(logic [31:0] l, logic [1:0] o, logic [7:0] b);
    logic [31:0] r;
    r = l;
    r[{o, 3'b000} +: 8] = b;
    return r;
  endfunction

  function automatic logic [7:0] get_byte(logic [31:0] l, logic [1:0] o);
    return l[{o, 3'b000} +: 8];
  endfunction

  assign req_ready     = (state == S_IDLE);
  assign mem_req_valid = (state == S_WB) || (state == S_FILL);
  assign mem_req_write = (state == S_WB);
  assign mem_req_addr  = (state == S_WB) ? {tags[q_way][set_i], set_i} : q_addr[ADDR_W-1:2];
  assign mem_req_wdata = lines[q_way][set_i];

  always_ff @(posedge clk) begin
    if (state == S_CMP && hit && q_write)
      lines[hway][set_i] <= put_byte(lines[hway][set_i], off_i, q_wdata);
    if (state == S_FILL && mem_resp_valid) begin
      lines[q_way][set_i] <= q_write ? put_byte(mem_resp_rdata, off_i, q_wdata) : mem_resp_rdata;
      tags[q_way][set_i]  <= tag_i;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      q_write    <= 1'b0;
      q_addr     <= '0;
      q_wdata    <= '0;
      q_way      <= 1'b0;
      vld[0]     <= '0;
      vld[1]     <= '0;
      dirty[0]   <= '0;
      dirty[1]   <= '0;
      lru        <= '0;
      resp_valid <= 1'b0;
      resp_rdata <= '0;
    end else begin
      resp_valid <= 1'b0;
      case (state)
        S_IDLE: if (req_valid) begin
          q_write <= req_write;
          q_addr  <= req_addr;
          q_wdata <= req_wdata;
          state   <= S_CMP;
        end
        S_CMP: if (hit) begin
          lru[set_i] <= ~hway;
          if (q_write) dirty[hway][set_i] <= 1'b1;
          resp_valid <= 1'b1;
          resp_rdata <= q_write ? 8'h00 : get_byte(lines[hway][set_i], off_i);
          state      <= S_IDLE;
        end else begin
          q_way <= vway;
          state <= (vld[vway][set_i] && dirty[vway][set_i]) ? S_WB : S_FILL;
        end
        S_WB: if (mem_resp_valid) state <= S_FILL;
        S_FILL: if (mem_resp_valid) begin
          vld[q_way][set_i]   <= 1'b1;
          dirty[q_way][set_i] <= q_write;
          lru[set_i]          <= ~q_way;
          resp_valid <= 1'b1;
          resp_rdata <= q_write ? 8'h00 : get_byte(mem_resp_rdata, off_i);
          state      <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cache2w_chk.sv
module cache2w_chk #(
  parameter int ADDR_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              resp_valid,
  input logic              mem_req_valid,
  input logic              mem_req_write,
  input logic [ADDR_W-3:0] mem_req_addr,
  input logic [31:0]       mem_req_wdata,
  input logic              mem_resp_valid
);
  assert_resp_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |=> !resp_valid);

  assert_busy_not_ready_R12: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !req_ready);

  assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_resp_valid) |=>
      (mem_req_valid && $stable(mem_req_write) && $stable(mem_req_addr) && $stable(mem_req_wdata)));

  assert_wb_then_fill_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_write && mem_resp_valid) |=> (mem_req_valid && !mem_req_write));

  assert_fill_ends_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_write && mem_resp_valid) |=> (resp_valid && !mem_req_valid));

  assert_reset_idle_R2: assert property (@(posedge clk)
    !rst_n |=> (req_ready && !resp_valid && !mem_req_valid));
endmodule

bind cache2w cache2w_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .resp_valid(resp_valid),
  .mem_req_valid(mem_req_valid), .mem_req_write(mem_req_write),
  .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
  .mem_resp_valid(mem_resp_valid)
);

// File: tb/sim_cache2w.sv
module sim_cache2w;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [23:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        req_ready, resp_valid;
  logic [7:0]  resp_rdata;
  logic        mem_req_valid, mem_req_write;
  logic [21:0] mem_req_addr;
  logic [31:0] mem_req_wdata;
  logic        mem_resp_valid = 1'b0;
  logic [31:0] mem_resp_rdata = '0;

  int checks = 0, errors = 0, cycles = 0;
  int n_rd = 0, n_wr = 0, dly = 0;
  logic [21:0] last_raddr = '0, last_waddr = '0;
  logic [31:0] last_wdata = '0;
  logic [31:0] mem [256];
  logic [7:0]  gold [1024];

  always #10 clk = ~clk;

  cache2w #(.ADDR_W(24), .SET_BITS(2)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .resp_valid(resp_valid), .resp_rdata(resp_rdata),
    .mem_req_valid(mem_req_valid), .mem_req_write(mem_req_write),
    .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
    .mem_resp_valid(mem_resp_valid), .mem_resp_rdata(mem_resp_rdata)
  );

  function automatic logic [7:0] f(int a);
    return 8'((a * 37 + 11) & 255);
  endfunction

  always @(posedge clk) begin
    cycles <= cycles + 1;
    mem_resp_valid <= 1'b0;
    if (mem_req_valid && !mem_resp_valid) begin
      if (dly == 2) begin
        dly <= 0;
        mem_resp_valid <= 1'b1;
        if (mem_req_write) begin
          mem[mem_req_addr[7:0]] <= mem_req_wdata;
          n_wr <= n_wr + 1;
          last_waddr <= mem_req_addr;
          last_wdata <= mem_req_wdata;
        end else begin
          mem_resp_rdata <= mem[mem_req_addr[7:0]];
          n_rd <= n_rd + 1;
          last_raddr <= mem_req_addr;
        end
      end else dly <= dly + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic acc(input bit w, input int a, input logic [7:0] d, output logic [7:0] r);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_addr = 24'(a); req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    while (!resp_valid) @(negedge clk);
    r = resp_rdata;
    @(negedge clk);
    chk(!resp_valid, "R12 single pulse", 64'(resp_valid), 0);
    if (w) gold[a] = d;
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (cycles > 150000) begin
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    logic [7:0] r;
    int rd0, wr0;
    for (int b = 0; b < 256; b++)
      mem[b] = {f(4*b+3), f(4*b+2), f(4*b+1), f(4*b)};
    for (int a = 0; a < 1024; a++) gold[a] = f(a);
    repeat (3) @(negedge clk);
    chk(req_ready && !resp_valid && !mem_req_valid, "R2 reset state",
        {req_ready, resp_valid, mem_req_valid}, 3'b100);
    rst_n = 1'b1;

    // R4 R1: read miss, block address and byte select
    rd0 = n_rd;
    acc(0, 'h001, 0, r);
    chk(r == f('h001), "R4 miss data", r, f('h001));
    chk(n_rd == rd0 + 1 && last_raddr == 22'h0, "R1 fetch block address", last_raddr, 0);
    // R7: second tag in set 0 fills the invalid way, both stay
    acc(0, 'h012, 0, r);
    chk(r == f('h012), "R7 second way data", r, f('h012));
    rd0 = n_rd;
    acc(0, 'h003, 0, r);
    chk(r == f('h003) && n_rd == rd0, "R3 hit no traffic", n_rd - rd0, 0);
    acc(0, 'h013, 0, r);
    chk(r == f('h013) && n_rd == rd0, "R7 invalid way used first", n_rd - rd0, 0);
    // R8 R10: block 0 most recent -> block 0x10 evicted clean
    acc(0, 'h000, 0, r);
    rd0 = n_rd; wr0 = n_wr;
    acc(0, 'h020, 0, r);
    chk(n_wr == wr0, "R10 clean victim no write", n_wr - wr0, 0);
    chk(r == f('h020) && n_rd == rd0 + 1, "R4 refill", r, f('h020));
    rd0 = n_rd;
    acc(0, 'h002, 0, r);
    chk(n_rd == rd0, "R8 recent block kept", n_rd - rd0, 0);
    acc(0, 'h011, 0, r);
    chk(n_rd == rd0 + 1 && r == f('h011), "R8 LRU block was evicted", n_rd - rd0, 1);
    // set 0 now: block 0 and block 0x10 (0x20 evicted)
    rd0 = n_rd; wr0 = n_wr;
    acc(1, 'h001, 8'hA5, r);
    chk(n_rd == rd0 && n_wr == wr0 && r == 8'h00, "R5 write hit no traffic", n_rd - rd0 + n_wr - wr0, 0);
    acc(0, 'h001, 0, r);
    chk(r == 8'hA5, "R5 write hit readback", r, 8'hA5);
    acc(0, 'h011, 0, r);
    rd0 = n_rd; wr0 = n_wr;
    acc(0, 'h030, 0, r);
    chk(n_wr == wr0 + 1 && last_waddr == 22'h0, "R9 dirty victim address", last_waddr, 0);
    chk(last_wdata == {f(3), f(2), 8'hA5, f(0)}, "R9 written line",
        last_wdata, {f(3), f(2), 8'hA5, f(0)});
    chk(n_rd == rd0 + 1 && r == f('h030), "R9 refill after write-back", r, f('h030));
    // R6: write miss in empty set 1
    rd0 = n_rd; wr0 = n_wr;
    acc(1, 'h045, 8'h3C, r);
    chk(n_rd == rd0 + 1 && n_wr == wr0, "R6 allocate fetch", n_rd - rd0, 1);
    acc(0, 'h045, 0, r);
    chk(r == 8'h3C, "R6 merged byte", r, 8'h3C);
    acc(0, 'h044, 0, r);
    chk(r == f('h044) && n_rd == rd0 + 1, "R6 other bytes kept", r, f('h044));

    // R1 R3 R4 R9 R10 sweeps against golden image
    for (int pass = 0; pass < 2; pass++) begin
      for (int a = 0; a < 1024; a++) begin
        acc(0, a, 0, r);
        chk(r == gold[a], "R1 sweep read", r, gold[a]);
      end
      for (int i = 0; i < 300; i++)
        acc(1, (i * 13 + pass * 7) % 1024, 8'(i ^ 8'h5A ^ pass), r);
    end
    for (int a = 1023; a >= 0; a--) begin
      acc(0, a, 0, r);
      chk(r == gold[a], "R9 final read", r, gold[a]);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule